// File: doc/BRIEF.md
# DAC Output Override Controller

This block is the digital control core of an eight-channel voltage-output DAC. For each channel the register file supplies a 12-bit output code and a 2-bit power-down code. Six active-low pins can take over from those stored settings. Three of them pin every output code to zero, to midscale or to full scale. A lockout pin holds every channel powered up. Two shutdown pins put every channel into one of the terminated shutdown modes. The pins only mask the stored settings. They never change them, so the register contents apply again once every pin is released.

The block keeps a snapshot of each channel's power-down code, taken when the lockout pin is pulled low. When lockout ends, a channel goes back to its snapshot if its power-down bits were not written during the lockout. If they were written, the channel takes the newly written register value. The block also flags illegal pin combinations. It marks a channel's data for reload when a force pin falls while that channel's register write is in progress.

All pins pass through a two-flop synchroniser. The code and mode outputs are combinational from the synchronised pins and the register inputs.

Top module: `dac_ovr_ctrl`

## Requirements
- R1: While the synchronised force-zero pin is low, every channel's output code is 12'h000, whatever the other force pins do.
- R2: While force-midscale is low and force-zero is high, every output code is 12'h800, whatever the force-full-scale pin does.
- R3: While force-full-scale is the only force pin low, every output code is 12'hFFF.
- R4: With all force pins high, each channel's output code equals its register code in the same cycle.
- R5: `force_err_o` is 1 exactly when two or more force pins are low after synchronisation.
- R6: With no power pin low and no snapshot held, each channel's mode equals its stored power-down code. The encoding is 2'b00 active, 2'b01 1k to ground, 2'b10 100k, 2'b11 high impedance.
- R7: While lockout is low and both shutdown pins are high, every channel's mode is 2'b00. The stored bits are not altered.
- R8: After lockout is released, a channel whose power-down write strobe did not fire during the lockout uses the code captured when lockout fell. It keeps that code until its next strobe, even if its register input changed in the meantime.
- R9: A strobe during lockout sets that channel's bit of `pd_rewr_o`. After release, that channel uses its current register bits. The flag clears at the next fall of lockout.
- R10: While the 1k shutdown pin is low, every mode is 2'b01. This pin takes precedence over the 100k pin and over lockout.
- R11: While the 100k shutdown pin is the only shutdown pin low, every mode is 2'b10, or 2'b11 when `HIZ_VARIANT` is 1. This pin takes precedence over lockout.
- R12: `lock_err_o` is 1 exactly when lockout and at least one shutdown pin are low after synchronisation.
- R13: A force pin falling while a channel's `wr_busy_i` bit is 1 sets that channel's `reload_o` bit on the next clock. The bit clears on the next clock after a rising edge of `wr_busy_i` that does not coincide with a new force fall.
- R14: A pin change reaches the outputs two clock edges after it is sampled. On reset every flag is 0, no snapshot is held, and the synchroniser stages read inactive (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_code_i | input | NCH*DW | Register codes, channel 0 in the low bits |
| pd_bits_i | input | NCH*2 | Stored power-down codes, 2 bits per channel |
| pd_wr_i | input | NCH | Per-channel strobe: power-down bits written this cycle |
| wr_busy_i | input | NCH | Per-channel register write in progress |
| force_full_n | input | 1 | Async, active low: all codes full scale |
| force_mid_n | input | 1 | Async, active low: all codes midscale |
| force_zero_n | input | 1 | Async, active low: all codes zero |
| lock_n | input | 1 | Async, active low: power-down lockout |
| sd1k_n | input | 1 | Async, active low: shutdown with 1k to ground |
| sd100k_n | input | 1 | Async, active low: shutdown with 100k or high impedance |
| out_code_o | output | NCH*DW | Effective output code per channel |
| out_mode_o | output | NCH*2 | Effective power mode per channel |
| reload_o | output | NCH | Channel data needs a reload |
| pd_rewr_o | output | NCH | Power-down bits written during the latest lockout |
| force_err_o | output | 1 | Two or more force pins low |
| lock_err_o | output | 1 | Lockout low together with a shutdown pin |

## Verification
A stale or corrupted snapshot stays hidden while lockout is held, because every mode then reads active. It shows up as a wrong `out_mode_o` two edges after lockout is released. It stays wrong until that channel's next power-down strobe. A stuck synchroniser stage or a wrong priority order shows up on every channel at once, two edges after the pin change. A reload or rewrite flag that sets or clears on the wrong edge shows up on its own output one clock after the triggering event.

// File: rtl/dac_ovr_pkg.sv
// Package: shared power-mode encoding and force-code constants.
// Assumes 2-bit power-down codes as the register file stores them.
package dac_ovr_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE = 2'b00,
        PM_TERM1K = 2'b01,
        PM_TERM100K = 2'b10,
        PM_HIZ = 2'b11
    } pmode_e;

    // Midscale code: top bit set, rest clear, for any code width.
    function automatic logic [31:0] mid_code(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction
endpackage

// File: rtl/dac_pin_sync.sv
// Module: dac_pin_sync
// Brings NPIN asynchronous active-low pins into the clock domain through
// STAGES flip-flops per pin. Reset loads the inactive (high) level.
// Assumes the pins are glitch-free and held for more than one clock.
module dac_pin_sync #(
    parameter int NPIN   = 6,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_n_i,
    output logic [NPIN-1:0] pin_n_o
);
    genvar g;
    generate
        for (g = 0; g < NPIN; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            // Shift the pin level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], pin_n_i[g]};
            end
            assign pin_n_o[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dac_lock_track.sv
// Module: dac_lock_track
// Per-channel state: the power-down snapshot taken at lockout entry, a
// hold flag that selects the snapshot until the next write, the
// rewritten-during-lockout flag and the reload flag.
// Assumes the lockout and force inputs are already synchronised and active high.
module dac_lock_track #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lock_a,
    input  logic [2:0]     force_a,
    input  logic [NCH*2-1:0] pd_bits_i,
    input  logic [NCH-1:0] pd_wr_i,
    input  logic [NCH-1:0] wr_busy_i,
    output logic [NCH*2-1:0] snap_o,
    output logic [NCH-1:0] held_o,
    output logic [NCH-1:0] rewr_o,
    output logic [NCH-1:0] reload_o
);
    logic       lock_q;
    logic [2:0] force_q;
    logic       lock_fall;
    logic       force_fall;

    // Remember last-cycle pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            force_q <= 3'b000;
        end else begin
            lock_q  <= lock_a;
            force_q <= force_a;
        end
    end

    assign lock_fall  = lock_a & ~lock_q;
    assign force_fall = |(force_a & ~force_q);

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic [1:0] snap_q;
            logic       held_q, rewr_q, reload_q, busy_q;

            // Capture the snapshot at lockout entry; a strobe drops it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    snap_q <= 2'b00;
                    held_q <= 1'b0;
                end else if (lock_fall) begin
                    snap_q <= pd_bits_i[2*c +: 2];
                    held_q <= 1'b1;
                end else if (pd_wr_i[c]) begin
                    held_q <= 1'b0;
                end
            end

            // Track a power-down write during the current lockout.
            always_ff @(posedge clk) begin
                if (!rst_n)                   rewr_q <= 1'b0;
                else if (lock_fall)           rewr_q <= pd_wr_i[c];
                else if (lock_a && pd_wr_i[c]) rewr_q <= 1'b1;
            end

            // Mark reload on a force fall during a write; clear on a new write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    reload_q <= 1'b0;
                    busy_q   <= 1'b0;
                end else begin
                    busy_q <= wr_busy_i[c];
                    if (force_fall && wr_busy_i[c])   reload_q <= 1'b1;
                    else if (wr_busy_i[c] && !busy_q) reload_q <= 1'b0;
                end
            end

            assign snap_o[2*c +: 2] = snap_q;
            assign held_o[c]        = held_q;
            assign rewr_o[c]        = rewr_q;
            assign reload_o[c]      = reload_q;
        end
    endgenerate
endmodule

// File: rtl/dac_chan_sel.sv
// Module: dac_chan_sel
// Combinational selection of one channel's effective code and power mode.
// Code priority: zero, midscale, full scale, register.
// Mode priority: 1k shutdown, 100k/high-Z shutdown, lockout (active),
// snapshot when held, stored bits.
module dac_chan_sel
    import dac_ovr_pkg::*;
#(
    parameter int DW          = 12,
    parameter bit HIZ_VARIANT = 1'b0
) (
    input  logic [DW-1:0] reg_code_i,
    input  logic [1:0]    pd_bits_i,
    input  logic [1:0]    snap_i,
    input  logic          held_i,
    input  logic          zero_a,
    input  logic          mid_a,
    input  logic          full_a,
    input  logic          lock_a,
    input  logic          sd1k_a,
    input  logic          sd100k_a,
    output logic [DW-1:0] code_o,
    output logic [1:0]    mode_o
);
    localparam logic [DW-1:0] MID_CODE = DW'(mid_code(DW));
    localparam pmode_e SD_ALT = HIZ_VARIANT ? PM_HIZ : PM_TERM100K;

    // Pick the output code by override priority.
    always_comb begin
        if (zero_a)      code_o = '0;
        else if (mid_a)  code_o = MID_CODE;
        else if (full_a) code_o = '1;
        else             code_o = reg_code_i;
    end

    // Pick the power mode by override priority.
    always_comb begin
        if (sd1k_a)        mode_o = PM_TERM1K;
        else if (sd100k_a) mode_o = SD_ALT;
        else if (lock_a)   mode_o = PM_ACTIVE;
        else if (held_i)   mode_o = snap_i;
        else               mode_o = pd_bits_i;
    end
endmodule

// File: rtl/dac_ovr_ctrl.sv
// Module: dac_ovr_ctrl (top)
// Applies the asynchronous override pins to the eight channels' register
// codes and power-down codes without changing the stored values, flags
// illegal pin combinations, and tracks lockout and reload state.
// Assumes the register file presents its contents continuously and
// pulses pd_wr_i for one clock on every power-down write.
module dac_ovr_ctrl #(
    parameter int NCH         = 8,
    parameter int DW          = 12,
    parameter int SYNC_STAGES = 2,
    parameter bit HIZ_VARIANT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] reg_code_i,
    input  logic [NCH*2-1:0]  pd_bits_i,
    input  logic [NCH-1:0]    pd_wr_i,
    input  logic [NCH-1:0]    wr_busy_i,
    input  logic              force_full_n,
    input  logic              force_mid_n,
    input  logic              force_zero_n,
    input  logic              lock_n,
    input  logic              sd1k_n,
    input  logic              sd100k_n,
    output logic [NCH*DW-1:0] out_code_o,
    output logic [NCH*2-1:0]  out_mode_o,
    output logic [NCH-1:0]    reload_o,
    output logic [NCH-1:0]    pd_rewr_o,
    output logic              force_err_o,
    output logic              lock_err_o
);
    localparam int NPIN = 6;

    logic [NPIN-1:0]  pins_s;
    logic             zero_a, mid_a, full_a, lock_a, sd1k_a, sd100k_a;
    logic [NCH*2-1:0] snap;
    logic [NCH-1:0]   held;

    dac_pin_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n_i({sd100k_n, sd1k_n, lock_n, force_zero_n, force_mid_n, force_full_n}),
        .pin_n_o(pins_s)
    );

    assign full_a   = ~pins_s[0];
    assign mid_a    = ~pins_s[1];
    assign zero_a   = ~pins_s[2];
    assign lock_a   = ~pins_s[3];
    assign sd1k_a   = ~pins_s[4];
    assign sd100k_a = ~pins_s[5];

    assign force_err_o = (zero_a & mid_a) | (zero_a & full_a) | (mid_a & full_a);
    assign lock_err_o  = lock_a & (sd1k_a | sd100k_a);

    dac_lock_track #(.NCH(NCH)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_a   (lock_a),
        .force_a  ({zero_a, mid_a, full_a}),
        .pd_bits_i(pd_bits_i),
        .pd_wr_i  (pd_wr_i),
        .wr_busy_i(wr_busy_i),
        .snap_o   (snap),
        .held_o   (held),
        .rewr_o   (pd_rewr_o),
        .reload_o (reload_o)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_sel
            dac_chan_sel #(.DW(DW), .HIZ_VARIANT(HIZ_VARIANT)) u_sel (
                .reg_code_i(reg_code_i[DW*c +: DW]),
                .pd_bits_i (pd_bits_i[2*c +: 2]),
                .snap_i    (snap[2*c +: 2]),
                .held_i    (held[c]),
                .zero_a    (zero_a),
                .mid_a     (mid_a),
                .full_a    (full_a),
                .lock_a    (lock_a),
                .sd1k_a    (sd1k_a),
                .sd100k_a  (sd100k_a),
                .code_o    (out_code_o[DW*c +: DW]),
                .mode_o    (out_mode_o[2*c +: 2])
            );
        end
    endgenerate
endmodule

// File: rtl/dac_ovr_chk.sv
// Module: dac_ovr_chk
// Property checker for dac_ovr_ctrl, attached by bind. It relates the
// synchroniser outputs to the channel outputs and flags.
module dac_ovr_chk #(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        pins_s,
    input logic [NCH*DW-1:0] out_code_o,
    input logic [NCH*2-1:0]  out_mode_o,
    input logic [NCH-1:0]    reload_o,
    input logic [NCH-1:0]    wr_busy_i,
    input logic              force_err_o,
    input logic              lock_err_o
);
    localparam logic [DW-1:0] MIDV = {1'b1, {(DW-1){1'b0}}};

    function automatic logic all_codes(input logic [NCH*DW-1:0] v, input logic [DW-1:0] k);
        for (int i = 0; i < NCH; i++) if (v[DW*i +: DW] != k) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic all_modes(input logic [NCH*2-1:0] v, input logic [1:0] k);
        for (int i = 0; i < NCH; i++) if (v[2*i +: 2] != k) return 1'b0;
        return 1'b1;
    endfunction

    // R1: force-zero clears every code
    p_zero_codes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_s[2] |-> all_codes(out_code_o, '0));
    // R2: midscale when zero is inactive
    p_mid_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[2] && !pins_s[1]) |-> all_codes(out_code_o, MIDV));
    // R3: full scale alone
    p_full_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[2:0] == 3'b110) |-> all_codes(out_code_o, '1));
    // R5: two or more force pins low raise the error
    p_force_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~pins_s[2:0]) >= 2) |-> force_err_o);
    // R7: lockout alone forces active
    p_lock_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[5:3] == 3'b110) |-> all_modes(out_mode_o, 2'b00));
    // R10: 1k shutdown wins
    p_sd1k_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_s[4] |-> all_modes(out_mode_o, 2'b01));
    // R12: lockout with a shutdown pin is illegal
    p_lock_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_s[3] && !(pins_s[4] && pins_s[5])) |-> lock_err_o);
    // R13: a reload flag only rises for a channel that was busy
    p_reload_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_o[0]) |-> $past(wr_busy_i[0]));
endmodule

bind dac_ovr_ctrl dac_ovr_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_s     (pins_s),
    .out_code_o (out_code_o),
    .out_mode_o (out_mode_o),
    .reload_o   (reload_o),
    .wr_busy_i  (wr_busy_i),
    .force_err_o(force_err_o),
    .lock_err_o (lock_err_o)
);

// File: tb/tb_dac_ovr_ctrl.sv
module tb_dac_ovr_ctrl;
    localparam int NCH = 8;
    localparam int DW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] reg_code_i = '0;
    logic [NCH*2-1:0]  pd_bits_i = '0;
    logic [NCH-1:0]    pd_wr_i = '0;
    logic [NCH-1:0]    wr_busy_i = '0;
    logic force_full_n = 1'b1, force_mid_n = 1'b1, force_zero_n = 1'b1;
    logic lock_n = 1'b1, sd1k_n = 1'b1, sd100k_n = 1'b1;
    logic [NCH*DW-1:0] out_code_o;
    logic [NCH*2-1:0]  out_mode_o;
    logic [NCH-1:0]    reload_o, pd_rewr_o;
    logic              force_err_o, lock_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    dac_ovr_ctrl dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] rep_code(input logic [DW-1:0] k);
        logic [NCH*DW-1:0] v;
        for (int i = 0; i < NCH; i++) v[DW*i +: DW] = k;
        return v;
    endfunction

    function automatic logic [NCH*2-1:0] rep_mode(input logic [1:0] k);
        logic [NCH*2-1:0] v;
        for (int i = 0; i < NCH; i++) v[2*i +: 2] = k;
        return v;
    endfunction

    // Wait for a pin change to pass the two synchroniser edges.
    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R14 reload", reload_o, '0);
        chk("R14 rewr", pd_rewr_o, '0);
        chk("R14 errs", {force_err_o, lock_err_o}, 2'b00);
        chk("R14 mode", out_mode_o, pd_bits_i);
    endtask

    task automatic t_passthrough();
        for (int i = 0; i < NCH; i++) reg_code_i[DW*i +: DW] = DW'(12'h123 * (i + 1));
        @(negedge clk);
        chk("R4", out_code_o, reg_code_i);
        reg_code_i[DW*3 +: DW] = 12'hABC;
        #1 chk("R4 same cycle", out_code_o, reg_code_i);
    endtask

    task automatic t_force();
        @(negedge clk) force_full_n = 1'b0;
        @(negedge clk);
        chk("R14 one edge", out_code_o, reg_code_i);
        @(negedge clk);
        chk("R3", out_code_o, rep_code(12'hFFF));
        chk("R5 single", force_err_o, 1'b0);
        force_mid_n = 1'b0; settle();
        chk("R2", out_code_o, rep_code(12'h800));
        chk("R5 two", force_err_o, 1'b1);
        force_zero_n = 1'b0; settle();
        chk("R1", out_code_o, rep_code(12'h000));
        force_full_n = 1'b1; force_mid_n = 1'b1; settle();
        chk("R1 alone", out_code_o, rep_code(12'h000));
        chk("R5 clear", force_err_o, 1'b0);
        force_zero_n = 1'b1; settle();
        chk("R4 release", out_code_o, reg_code_i);
    endtask

    task automatic t_modes();
        pd_bits_i = 16'b11_10_01_00_11_10_01_00;
        @(negedge clk);
        chk("R6", out_mode_o, pd_bits_i);
        sd100k_n = 1'b0; settle();
        chk("R11", out_mode_o, rep_mode(2'b10));
        sd1k_n = 1'b0; settle();
        chk("R10 over 100k", out_mode_o, rep_mode(2'b01));
        lock_n = 1'b0; settle();
        chk("R10 over lock", out_mode_o, rep_mode(2'b01));
        chk("R12 set", lock_err_o, 1'b1);
        sd1k_n = 1'b1; settle();
        chk("R11 over lock", out_mode_o, rep_mode(2'b10));
        chk("R12 100k", lock_err_o, 1'b1);
        sd100k_n = 1'b1; settle();
        chk("R12 clear", lock_err_o, 1'b0);
        chk("R7", out_mode_o, rep_mode(2'b00));
        chk("R6 stored kept", pd_bits_i, 16'b11_10_01_00_11_10_01_00);
        lock_n = 1'b1; settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_lock_release();
        logic [NCH*2-1:0] exp;
        pd_wr_i = '1; @(negedge clk); pd_wr_i = '0;
        pd_bits_i = 16'b01_01_01_01_10_10_11_11;
        @(negedge clk);
        chk("R6 fresh", out_mode_o, pd_bits_i);
        lock_n = 1'b0; repeat (4) @(negedge clk);
        chk("R7 lock", out_mode_o, rep_mode(2'b00));
        // Channel 1 gets a strobed write; channel 2 changes without a strobe.
        pd_bits_i[2*1 +: 2] = 2'b00; pd_wr_i[1] = 1'b1;
        @(negedge clk); pd_wr_i = '0;
        pd_bits_i[2*2 +: 2] = 2'b00;
        @(negedge clk);
        chk("R9 flag", pd_rewr_o, 8'b0000_0010);
        lock_n = 1'b1; settle();
        exp = 16'b01_01_01_01_10_10_11_11;
        exp[2*1 +: 2] = 2'b00;
        chk("R8 R9 release", out_mode_o, exp);
        pd_wr_i[2] = 1'b1; @(negedge clk); pd_wr_i = '0;
        #1 chk("R8 drop on write", out_mode_o[2*2 +: 2], 2'b00);
        lock_n = 1'b0; repeat (4) @(negedge clk);
        chk("R9 clear on fall", pd_rewr_o, 8'h00);
        lock_n = 1'b1; repeat (3) @(negedge clk);
    endtask

    task automatic t_reload();
        wr_busy_i = 8'b0000_0100;
        force_mid_n = 1'b0; repeat (3) @(negedge clk);
        chk("R13 set", reload_o, 8'b0000_0100);
        wr_busy_i = '0; force_mid_n = 1'b1; repeat (3) @(negedge clk);
        chk("R13 hold", reload_o, 8'b0000_0100);
        wr_busy_i[2] = 1'b1; @(negedge clk);
        chk("R13 clear", reload_o, 8'h00);
        wr_busy_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_force();
        t_modes();
        t_lock_release();
        t_reload();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule